// File: doc/BRIEF.md
# Synchronous Burst Memory Core

This block is a clocked memory whose word is split into byte lanes. Each lane carries eight data bits and one parity bit. The default build has two lanes, which gives an 18-bit word, and 256 words. On every rising clock edge the block samples three enables, two start strobes, an advance strobe and the write controls. From these it picks one cycle type: deselect, start a burst, step to the next burst address, hold the current address, or do nothing. Bursts always span four words, and the address steps through a small counter on the low two address bits.

A host starts an access with one of two strobes. The processor strobe can only start a read. The controller strobe starts a read or a write, chosen by the write controls. After a burst has started, cycles with no strobe either step the address or hold it. Each of these cycles reads or writes depending on the write controls. Read data is flow-through: the word used at an edge appears on `rdata` during the cycle that follows. Two inputs act on the output enable without waiting for a clock: output enable and sleep.

Top module: `burst_sram_core`

## Requirements
- R1: The block counts as selected only when `cs0_n` is 0, `cs1` is 1 and `cs2_n` is 0. An edge with either start strobe low while the block is not selected is a deselect cycle. It writes nothing, ends any burst, and leaves `rdata_en` at 0 for the next cycle.
- R2: An edge with `proc_start_n` low while selected loads `addr` and starts a read burst. It writes nothing, whatever the write controls say.
- R3: An edge with `ctrl_start_n` low, `proc_start_n` high and the block selected loads `addr`. It writes at that address if the write decode is active, and reads it otherwise.
- R4: The write decode is active when `wr_all_n` is 0, or when `byte_wr_n` is 0 and at least one bit of `lane_en_n` is 0. Otherwise the cycle is a read.
- R5: `wr_all_n` at 0 writes all 18 bits, whatever `byte_wr_n` and `lane_en_n` are.
- R6: `lane_en_n[0]` covers `wdata[7:0]` and parity `wdata[16]`. `lane_en_n[1]` covers `wdata[15:8]` and parity `wdata[17]`. Both act only while `byte_wr_n` is 0.
- R7: A burst is active and no strobe is low. If `adv_n` is 0 at that edge, the burst counter advances. The low two address bits are then start+count mod 4 when `lin_mode` is 1, and start XOR count when `lin_mode` is 0. The upper address bits stay fixed.
- R8: A burst is active, no strobe is low and `adv_n` is 1: the current address is reused. In both step and hold cycles, the write decode chooses write or read. This includes a write on the cycle right after a processor-started read.
- R9: After a read cycle, `rdata_en` is 1 while `oe_n` is 0 and `sleep` is 0. `rdata` then shows the word at that cycle's address. After a write cycle `rdata_en` is 0, whatever `oe_n` is.
- R10: `sleep` at 1 forces `rdata_en` to 0 at once. Every edge sampled with `sleep` at 1 is ignored: no write and no change of state.
- R11: After reset `rdata_en` is 0 and no burst is active. A strobe-free edge with no active burst does nothing.
- R12: When both strobes are low and the block is selected, the processor strobe wins and the cycle is a read with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | External word address |
| cs0_n | input | 1 | Enable, active low |
| cs1 | input | 1 | Enable, active high |
| cs2_n | input | 1 | Enable, active low |
| proc_start_n | input | 1 | Read-only start strobe, active low |
| ctrl_start_n | input | 1 | Read/write start strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high holds the address |
| wr_all_n | input | 1 | Write whole word, active low |
| byte_wr_n | input | 1 | Qualifies the lane enables, active low |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| lin_mode | input | 1 | 1 selects linear order, 0 selects interleaved order |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous standby, active high |
| wdata | input | LANES*9 | Write data: data bits first, parity bits on top |
| rdata | output | LANES*9 | Flow-through read data |
| rdata_en | output | 1 | Output driver enable for rdata |

## Verification
The properties assume that all synchronous inputs are free of X and change only between clock edges. They also assume that `oe_n` and `sleep` hold steady around each sampling edge, so that the output-enable checks compare values from the same cycle. The stimulus drives every input two nanoseconds after the rising edge and leaves it unchanged until the next one. The random part keeps the enables mostly asserted, so that bursts run long enough for their step and hold orderings to be covered.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

   localparam int BURST_CNT_W = 2;

   typedef enum logic [2:0] {
      CYC_NONE,
      CYC_DESEL,
      CYC_LOAD,
      CYC_HOLD,
      CYC_NEXT
   } cyc_e;

   // Low address bits for a given burst step.
   function automatic logic [BURST_CNT_W-1:0] burst_order(
      input logic [BURST_CNT_W-1:0] start,
      input logic [BURST_CNT_W-1:0] step,
      input logic                   linear
   );
      logic [BURST_CNT_W-1:0] sum;
      sum = start + step;
      return linear ? sum : (start ^ step);
   endfunction

endpackage

// File: rtl/burst_cycle_decode.sv
module burst_cycle_decode
   import burst_sram_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             cs0_n,
   input  logic             cs1,
   input  logic             cs2_n,
   input  logic             proc_start_n,
   input  logic             ctrl_start_n,
   input  logic             adv_n,
   input  logic             wr_all_n,
   input  logic             byte_wr_n,
   input  logic [LANES-1:0] lane_en_n,
   input  logic             sleep,
   input  logic             active,
   output cyc_e             cyc,
   output logic             do_read,
   output logic [LANES-1:0] lane_we
);

   logic             selected;
   logic [LANES-1:0] byte_req;
   logic [LANES-1:0] wr_mask;
   logic             wr_any;

   assign selected = ~cs0_n & cs1 & ~cs2_n;
   assign byte_req = ~lane_en_n & {LANES{~byte_wr_n}};
   assign wr_mask  = wr_all_n ? byte_req : {LANES{1'b1}};
   assign wr_any   = |wr_mask;

   always_comb begin
      cyc     = CYC_NONE;
      do_read = 1'b0;
      lane_we = '0;
      if (!sleep) begin
         if (!proc_start_n || !ctrl_start_n) begin
            if (!selected) begin
               cyc = CYC_DESEL;
            end else if (!proc_start_n) begin
               cyc     = CYC_LOAD;
               do_read = 1'b1;
            end else begin
               cyc     = CYC_LOAD;
               do_read = ~wr_any;
               lane_we = wr_mask;
            end
         end else if (active) begin
            cyc     = adv_n ? CYC_HOLD : CYC_NEXT;
            do_read = ~wr_any;
            lane_we = wr_mask;
         end
      end
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_e              cyc,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              lin_mode,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              active
);

   localparam int HI_W = ADDR_W - BURST_CNT_W;

   logic [HI_W-1:0]        hi_q;
   logic [BURST_CNT_W-1:0] start_q;
   logic [BURST_CNT_W-1:0] cnt_q;
   logic [BURST_CNT_W-1:0] cnt_nx;
   logic [ADDR_W-1:0]      cur_q;
   logic                   active_q;

   assign cnt_nx   = (cyc == CYC_NEXT) ? cnt_q + 1'b1 : cnt_q;
   assign acc_addr = (cyc == CYC_LOAD) ? ext_addr
                                       : {hi_q, burst_order(start_q, cnt_nx, lin_mode)};
   assign cur_addr = cur_q;
   assign active   = active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q     <= '0;
         start_q  <= '0;
         cnt_q    <= '0;
         cur_q    <= '0;
         active_q <= 1'b0;
      end else begin
         case (cyc)
            CYC_LOAD: begin
               hi_q     <= ext_addr[ADDR_W-1:BURST_CNT_W];
               start_q  <= ext_addr[BURST_CNT_W-1:0];
               cnt_q    <= '0;
               cur_q    <= acc_addr;
               active_q <= 1'b1;
            end
            CYC_DESEL: active_q <= 1'b0;
            CYC_HOLD, CYC_NEXT: begin
               cnt_q <= cnt_nx;
               cur_q <= acc_addr;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/burst_lane_store.sv
module burst_lane_store #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 2,
   parameter int BYTE_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          addr,
   input  logic                       cs0_n,
   input  logic                       cs1,
   input  logic                       cs2_n,
   input  logic                       proc_start_n,
   input  logic                       ctrl_start_n,
   input  logic                       adv_n,
   input  logic                       wr_all_n,
   input  logic                       byte_wr_n,
   input  logic [LANES-1:0]           lane_en_n,
   input  logic                       lin_mode,
   input  logic                       oe_n,
   input  logic                       sleep,
   input  logic [LANES*(BYTE_W+1)-1:0] wdata,
   output logic [LANES*(BYTE_W+1)-1:0] rdata,
   output logic                       rdata_en
);

   localparam int DATA_W = LANES * BYTE_W;
   localparam int WORD_W = DATA_W + LANES;
   localparam int LANE_W = BYTE_W + 1;

   if (ADDR_W <= BURST_CNT_W) begin : g_bad_addr
      $error("ADDR_W must exceed the burst counter width");
   end
   if (LANES < 1 || BYTE_W < 1) begin : g_bad_lane
      $error("LANES and BYTE_W must be at least 1");
   end

   cyc_e              cyc;
   logic              do_read;
   logic [LANES-1:0]  lane_we;
   logic [ADDR_W-1:0] acc_addr;
   logic [ADDR_W-1:0] cur_addr;
   logic              burst_active;
   logic              rd_q;
   logic [WORD_W-1:0] rd_word;

   burst_cycle_decode #(.LANES(LANES)) u_decode (
      .cs0_n        (cs0_n),
      .cs1          (cs1),
      .cs2_n        (cs2_n),
      .proc_start_n (proc_start_n),
      .ctrl_start_n (ctrl_start_n),
      .adv_n        (adv_n),
      .wr_all_n     (wr_all_n),
      .byte_wr_n    (byte_wr_n),
      .lane_en_n    (lane_en_n),
      .sleep        (sleep),
      .active       (burst_active),
      .cyc          (cyc),
      .do_read      (do_read),
      .lane_we      (lane_we)
   );

   burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cyc      (cyc),
      .ext_addr (addr),
      .lin_mode (lin_mode),
      .acc_addr (acc_addr),
      .cur_addr (cur_addr),
      .active   (burst_active)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] lane_rd;
      burst_lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_store (
         .clk   (clk),
         .we    (lane_we[g]),
         .waddr (acc_addr),
         .wdata ({wdata[DATA_W+g], wdata[g*BYTE_W +: BYTE_W]}),
         .raddr (cur_addr),
         .rdata (lane_rd)
      );
      assign rd_word[g*BYTE_W +: BYTE_W] = lane_rd[BYTE_W-1:0];
      assign rd_word[DATA_W+g]           = lane_rd[BYTE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rd_q <= 1'b0;
      else if (cyc != CYC_NONE)  rd_q <= do_read;
   end

   assign rdata    = rd_word;
   assign rdata_en = rd_q & ~oe_n & ~sleep;

endmodule

// File: rtl/burst_sram_checker.sv
module burst_sram_checker #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs0_n,
   input logic              cs1,
   input logic              cs2_n,
   input logic              proc_start_n,
   input logic              ctrl_start_n,
   input logic              adv_n,
   input logic              wr_all_n,
   input logic              oe_n,
   input logic              sleep,
   input logic              rdata_en,
   input logic              active,
   input logic [ADDR_W-1:0] cur_addr
);

   logic sel;
   assign sel = ~cs0_n & cs1 & ~cs2_n;

   assert_desel_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && (!proc_start_n || !ctrl_start_n) && !sel) |=> !rdata_en);

   assert_proc_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !proc_start_n && sel) |=> (rdata_en == (!oe_n && !sleep)));

   assert_step_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && proc_start_n && ctrl_start_n && !adv_n && active)
         |=> $stable(cur_addr[ADDR_W-1:2]));

   assert_hold_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_start_n && ctrl_start_n && adv_n) |=> $stable(cur_addr));

   assert_write_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && proc_start_n && !ctrl_start_n && sel && !wr_all_n) |=> !rdata_en);

   assert_sleep_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !rdata_en);

   always @(posedge clk) begin
      if (!rst_n) assert_reset_off_R11: assert (!rdata_en);
   end

endmodule

bind burst_sram_core burst_sram_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cs0_n        (cs0_n),
   .cs1          (cs1),
   .cs2_n        (cs2_n),
   .proc_start_n (proc_start_n),
   .ctrl_start_n (ctrl_start_n),
   .adv_n        (adv_n),
   .wr_all_n     (wr_all_n),
   .oe_n         (oe_n),
   .sleep        (sleep),
   .rdata_en     (rdata_en),
   .active       (burst_active),
   .cur_addr     (cur_addr)
);

// File: tb/burst_sram_core_tb.sv
module burst_sram_core_tb;

   localparam int AW = 8;
   localparam int WW = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          cs0_n = 1'b0, cs1 = 1'b1, cs2_n = 1'b0;
   logic          proc_start_n = 1'b1, ctrl_start_n = 1'b1, adv_n = 1'b1;
   logic          wr_all_n = 1'b1, byte_wr_n = 1'b1;
   logic [1:0]    lane_en_n = 2'b11;
   logic          lin_mode = 1'b1, oe_n = 1'b0, sleep = 1'b0;
   logic [WW-1:0] wdata = '0;
   logic [WW-1:0] rdata;
   logic          rdata_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [WW-1:0] mref [256];
   logic          m_active = 1'b0, m_rd = 1'b0;
   logic [5:0]    m_hi = '0;
   logic [1:0]    m_start = '0, m_cnt = '0;
   logic [AW-1:0] m_cur = '0;

   always #4 clk = ~clk;

   burst_sram_core u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
      .proc_start_n(proc_start_n), .ctrl_start_n(ctrl_start_n), .adv_n(adv_n),
      .wr_all_n(wr_all_n), .byte_wr_n(byte_wr_n), .lane_en_n(lane_en_n),
      .lin_mode(lin_mode), .oe_n(oe_n), .sleep(sleep), .wdata(wdata),
      .rdata(rdata), .rdata_en(rdata_en)
   );

   function automatic logic [1:0] order_lo(input logic [1:0] s, input logic [1:0] k, input logic lin);
      logic [1:0] sum;
      sum = s + k;
      return lin ? sum : (s ^ k);
   endfunction

   task automatic apply_write(input logic [AW-1:0] a, input logic [1:0] msk);
      if (msk[0]) begin mref[a][7:0]  = wdata[7:0];  mref[a][16] = wdata[16]; end
      if (msk[1]) begin mref[a][15:8] = wdata[15:8]; mref[a][17] = wdata[17]; end
   endtask

   task automatic model_edge();
      logic       sel, wr;
      logic [1:0] byt, msk;
      if (sleep) return;
      sel = !cs0_n && cs1 && !cs2_n;
      byt = ~lane_en_n & {2{~byte_wr_n}};
      msk = !wr_all_n ? 2'b11 : byt;
      wr  = |msk;
      if (!proc_start_n || !ctrl_start_n) begin
         if (!sel) begin
            m_active = 1'b0; m_rd = 1'b0;
         end else begin
            m_hi = addr[7:2]; m_start = addr[1:0]; m_cnt = 2'd0;
            m_active = 1'b1; m_cur = addr;
            if (!proc_start_n) m_rd = 1'b1;
            else begin m_rd = !wr; apply_write(addr, msk); end
         end
      end else if (m_active) begin
         if (!adv_n) m_cnt = m_cnt + 2'd1;
         m_cur = {m_hi, order_lo(m_start, m_cnt, lin_mode)};
         m_rd  = !wr;
         apply_write(m_cur, msk);
      end
   endtask

   task automatic check(input string req);
      logic exp_en;
      exp_en = m_rd && !oe_n && !sleep;
      checks++;
      if (rdata_en !== exp_en) begin
         errors++;
         $display("FAIL %s rdata_en actual %b expected %b", req, rdata_en, exp_en);
      end
      if (exp_en) begin
         checks++;
         if (rdata !== mref[m_cur]) begin
            errors++;
            $display("FAIL %s rdata actual %h expected %h (addr %h)", req, rdata, mref[m_cur], m_cur);
         end
      end
   endtask

   task automatic idle();
      addr = '0; cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
      proc_start_n = 1'b1; ctrl_start_n = 1'b1; adv_n = 1'b1;
      wr_all_n = 1'b1; byte_wr_n = 1'b1; lane_en_n = 2'b11;
      oe_n = 1'b0; sleep = 1'b0; wdata = '0;
   endtask

   task automatic step(input string req);
      @(posedge clk);
      model_edge();
      #2;
      check(req);
      idle();
   endtask

   initial begin
      int seed;
      seed = $urandom(32'h5eed);
      idle();
      repeat (3) @(posedge clk);
      #2;
      check("R11 reset");
      rst_n = 1'b1;

      // preload every word with a full write (R5)
      for (int i = 0; i < 256; i++) begin
         ctrl_start_n = 1'b0; wr_all_n = 1'b0; addr = AW'(i);
         wdata = WW'(i * 1031 + 7);
         step("R5 preload");
      end

      // R11: no burst active after a deselect, strobe-free edges do nothing
      ctrl_start_n = 1'b0; cs1 = 1'b0; step("R1 deselect");
      adv_n = 1'b0; wr_all_n = 1'b0; wdata = 18'h3ffff; step("R11 idle no burst");

      // R2: processor strobe reads even with write controls active
      proc_start_n = 1'b0; addr = 8'h10; wr_all_n = 1'b0; wdata = 18'h15555; step("R2 read start");
      step("R2 hold reads unchanged word");

      // R7 linear order from 0x21
      lin_mode = 1'b1; proc_start_n = 1'b0; addr = 8'h21; step("R7 linear start");
      for (int i = 0; i < 4; i++) begin lin_mode = 1'b1; adv_n = 1'b0; step("R7 linear step"); end

      // R7 interleaved order from 0x32
      lin_mode = 1'b0; proc_start_n = 1'b0; addr = 8'h32; step("R7 interleaved start");
      for (int i = 0; i < 3; i++) begin lin_mode = 1'b0; adv_n = 1'b0; step("R7 interleaved step"); end

      // R3/R6: lane 0 only write through controller strobe
      ctrl_start_n = 1'b0; addr = 8'h40; byte_wr_n = 1'b0; lane_en_n = 2'b10;
      wdata = 18'h2abcd; step("R6 low lane write");
      proc_start_n = 1'b0; addr = 8'h40; step("R6 low lane readback");
      ctrl_start_n = 1'b0; addr = 8'h41; byte_wr_n = 1'b0; lane_en_n = 2'b01;
      wdata = 18'h1f00f; step("R6 high lane write");
      proc_start_n = 1'b0; addr = 8'h41; step("R6 high lane readback");

      // R4: lane enable without byte_wr_n is a read
      ctrl_start_n = 1'b0; addr = 8'h42; lane_en_n = 2'b00; wdata = 18'h00001; step("R4 lane enable ignored");
      step("R4 word unchanged");

      // R8: write on the hold cycle after a processor read
      proc_start_n = 1'b0; addr = 8'h50; step("R8 read start");
      wr_all_n = 1'b0; wdata = 18'h0beef; step("R8 hold write");
      step("R8 hold reads written word");

      // R1: deselect by the low-active enable suppresses write
      ctrl_start_n = 1'b0; cs2_n = 1'b1; wr_all_n = 1'b0; addr = 8'h60; wdata = 18'h12345; step("R1 deselect no write");
      proc_start_n = 1'b0; addr = 8'h60; step("R1 word unchanged");

      // R12: both strobes, processor wins
      proc_start_n = 1'b0; ctrl_start_n = 1'b0; wr_all_n = 1'b0; addr = 8'h70; wdata = 18'h0; step("R12 priority read");
      step("R12 word unchanged");

      // R9: oe_n high blocks output; write cycle ignores oe_n
      proc_start_n = 1'b0; addr = 8'h71; oe_n = 1'b1; step("R9 oe high");
      ctrl_start_n = 1'b0; addr = 8'h72; wr_all_n = 1'b0; wdata = 18'h3c3c3; step("R9 write cycle output off");

      // R10: sleep ignores the edge and disables output
      ctrl_start_n = 1'b0; wr_all_n = 1'b0; addr = 8'h80; sleep = 1'b1; wdata = 18'h0; step("R10 sleep");
      proc_start_n = 1'b0; addr = 8'h80; step("R10 word unchanged");

      // constrained random traffic
      for (int n = 0; n < 4000; n++) begin
         addr         = AW'($urandom);
         cs0_n        = ($urandom % 16) == 0;
         cs1          = ($urandom % 16) != 0;
         cs2_n        = ($urandom % 16) == 0;
         proc_start_n = ($urandom % 6) != 0;
         ctrl_start_n = ($urandom % 6) != 0;
         adv_n        = ($urandom % 3) == 0;
         wr_all_n     = ($urandom % 5) != 0;
         byte_wr_n    = ($urandom % 3) == 0;
         lane_en_n    = 2'($urandom);
         lin_mode     = (n / 500) % 2 == 0;
         oe_n         = ($urandom % 8) == 0;
         sleep        = ($urandom % 32) == 0;
         wdata        = WW'($urandom);
         step("R7 R8 R9 random");
      end

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule